// File: doc/BRIEF.md
# Double-Buffered Compare Update Controller with Automatic Lock

This block holds the compare values for a timer that has several compare channels. Software never writes an active compare register directly. It writes a per-channel staging register, and that write raises the channel's pending flag. When the counter reports an update condition, the staged values move into the active registers, but only while the update-lock flag is low. The counter itself lives outside this block and only supplies the update strobe.

The lock flag can be driven by software alone, or by hardware when automatic locking is switched on. Writing 1 to the automatic-lock enable raises the lock at once. The hardware then lowers the lock when every enabled channel holds a pending value. The next update condition moves all the staged values together and raises the lock again. A new set of compare values therefore never takes effect part-written. Disabled channels play no part in the release decision.

Top module: `cmp_update_ctrl`

## Requirements
- R1: After a synchronous reset, every active value is 0, every pending flag is 0 and the lock flag is 0.
- R2: A staging write to a channel sets that channel's pending flag on the next clock edge and leaves its active value unchanged in that cycle.
- R3: When the update strobe is high and the lock flag is low, each channel whose pending flag is 1 copies its staged value to its active value and clears its pending flag on the next edge. Channels with no pending value keep their active value.
- R4: While the lock flag is 1, an update strobe changes no active value and no pending flag.
- R5: A write of 1 to the automatic-lock enable (`alock_wr` high with `alock_wdata` = 1) sets the lock flag on the next edge, whatever else happens in that cycle.
- R6: With automatic locking on and the lock flag at 1, the lock flag drops on the edge after a cycle in which every channel with its `ch_en` bit at 1 has its pending flag at 1. Channels whose `ch_en` bit is 0 are ignored, so with no channel enabled the lock drops at once.
- R7: With automatic locking on and the lock flag at 0, an update strobe performs the transfer and sets the lock flag again on the same edge.
- R8: With automatic locking off, the lock flag changes only through a manual lock write (`lock_wr` high, the new value on `lock_wdata`).
- R9: A staging write in the same cycle as a transfer is kept. The old staged value goes to the active register, the new value stays staged, and the pending flag stays 1.
- R10: A manual lock write overrides the automatic release and re-arm in its cycle. A write of 1 to the automatic-lock enable overrides a manual lock write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stg_wr | input | NCH | Per-channel staging write strobe |
| stg_wdata | input | NCH*CW | Staging data, channel k in bits [k*CW +: CW] |
| ch_en | input | NCH | Channel enables considered by the automatic release |
| alock_wr | input | 1 | Write strobe for the automatic-lock enable |
| alock_wdata | input | 1 | Value written to the automatic-lock enable |
| lock_wr | input | 1 | Manual lock-flag write strobe |
| lock_wdata | input | 1 | Value for the manual lock write |
| upd | input | 1 | Update-condition strobe from the counter |
| act_val | output | NCH*CW | Active compare values, channel k in bits [k*CW +: CW] |
| pend | output | NCH | Per-channel pending (staged-value valid) flags |
| lock | output | 1 | Update-lock flag |

## Verification
Directed sequences cover the sequences that tell each rule apart. One writes the channels one at a time with automatic locking on, to show that the lock holds until the last enabled channel is written. One disables a channel, to show that its missing write does not block the release. One fires a strobe together with a staging write, to show that the new value is kept. One toggles the manual lock with automatic locking off, to show that the hardware leaves the lock alone. A long seeded random run then mixes writes, strobes, enable changes and lock writes. It separates the priority between forcing, manual writes, release and re-arm, and compares every output each cycle against a bench model built from the requirements.

// File: rtl/cmp_update_pkg.sv
package cmp_update_pkg;

    // What the lock flag does on the coming edge, in priority order.
    typedef enum logic [2:0] {
        LK_HOLD    = 3'd0,
        LK_FORCE   = 3'd1,
        LK_MANUAL  = 3'd2,
        LK_RELEASE = 3'd3,
        LK_REARM   = 3'd4
    } lock_evt_e;

    // Per-channel staging state.
    typedef struct packed {
        logic full;
        logic take;
    } slot_flags_t;

    // True when every enabled channel holds a pending value.
    function automatic logic enabled_all_pending(input logic [31:0] pend_v,
                                                 input logic [31:0] en_v,
                                                 input int unsigned n);
        logic ok;
        ok = 1'b1;
        for (int unsigned i = 0; i < n; i++) begin
            if (en_v[i] && !pend_v[i]) ok = 1'b0;
        end
        return ok;
    endfunction

endpackage

// File: rtl/cmp_slot.sv
module cmp_slot
    import cmp_update_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [CW-1:0] wdata,
    input  logic          upd,
    input  logic          lock,
    output logic [CW-1:0] act_q,
    output logic          pend_q
);

    logic [CW-1:0] stg_q;
    slot_flags_t   fl;

    always_comb begin
        fl.take = upd && !lock && pend_q;
        fl.full = wr || (pend_q && !fl.take);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q  <= '0;
            act_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            if (fl.take) act_q <= stg_q;
            if (wr)      stg_q <= wdata;
            pend_q <= fl.full;
        end
    end

    // R2: a staging write always leaves the slot pending
    a_r2_write_pends: assert property (@(posedge clk) disable iff (rst)
        wr |=> pend_q);

    // R3: a transfer without a concurrent write empties the slot
    a_r3_take_clears: assert property (@(posedge clk) disable iff (rst)
        (upd && !lock && pend_q && !wr) |=> !pend_q);

    // R4: no active change while locked
    a_r4_locked_hold: assert property (@(posedge clk) disable iff (rst)
        lock |=> $stable(act_q));

    // R9: a write in a transfer cycle stays pending
    a_r9_keep_new: assert property (@(posedge clk) disable iff (rst)
        (upd && !lock && wr) |=> pend_q);

endmodule

// File: rtl/cmp_lock_ctrl.sv
module cmp_lock_ctrl
    import cmp_update_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic alock_wr,
    input  logic alock_wdata,
    input  logic lock_wr,
    input  logic lock_wdata,
    input  logic upd,
    input  logic all_ready,
    output logic lock_q,
    output logic auto_q
);

    lock_evt_e evt;

    always_comb begin
        evt = LK_HOLD;
        if (alock_wr && alock_wdata)          evt = LK_FORCE;
        else if (lock_wr)                     evt = LK_MANUAL;
        else if (auto_q && lock_q && all_ready) evt = LK_RELEASE;
        else if (auto_q && !lock_q && upd)    evt = LK_REARM;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
            auto_q <= 1'b0;
        end else begin
            if (alock_wr) auto_q <= alock_wdata;
            unique case (evt)
                LK_FORCE:   lock_q <= 1'b1;
                LK_MANUAL:  lock_q <= lock_wdata;
                LK_RELEASE: lock_q <= 1'b0;
                LK_REARM:   lock_q <= 1'b1;
                default:    lock_q <= lock_q;
            endcase
        end
    end

    // R5: enabling automatic lock raises the flag
    a_r5_force_lock: assert property (@(posedge clk) disable iff (rst)
        (alock_wr && alock_wdata) |=> lock_q);

    // R6: release once all enabled channels are pending
    a_r6_release: assert property (@(posedge clk) disable iff (rst)
        (auto_q && lock_q && all_ready && !alock_wr && !lock_wr) |=> !lock_q);

    // R7: re-arm after a transfer
    a_r7_rearm: assert property (@(posedge clk) disable iff (rst)
        (auto_q && !lock_q && upd && !alock_wr && !lock_wr) |=> lock_q);

    // R8: without automatic lock only software moves the flag
    a_r8_manual_only: assert property (@(posedge clk) disable iff (rst)
        (!auto_q && !alock_wr && !lock_wr) |=> $stable(lock_q));

    // R10: manual write wins over release and re-arm
    a_r10_manual_wins: assert property (@(posedge clk) disable iff (rst)
        (lock_wr && !(alock_wr && alock_wdata)) |=> (lock_q == $past(lock_wdata)));

endmodule

// File: rtl/cmp_update_ctrl.sv
module cmp_update_ctrl
    import cmp_update_pkg::*;
#(
    parameter int NCH = 3,
    parameter int CW  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    stg_wr,
    input  logic [NCH*CW-1:0] stg_wdata,
    input  logic [NCH-1:0]    ch_en,
    input  logic              alock_wr,
    input  logic              alock_wdata,
    input  logic              lock_wr,
    input  logic              lock_wdata,
    input  logic              upd,
    output logic [NCH*CW-1:0] act_val,
    output logic [NCH-1:0]    pend,
    output logic              lock
);

    localparam int PADW = 32 - NCH;

    logic lock_q;
    logic auto_q;
    logic all_ready;

    always_comb begin
        all_ready = enabled_all_pending({{PADW{1'b0}}, pend},
                                        {{PADW{1'b0}}, ch_en}, NCH);
    end

    for (genvar k = 0; k < NCH; k++) begin : g_slot
        cmp_slot #(.CW(CW)) u_slot (
            .clk    (clk),
            .rst    (rst),
            .wr     (stg_wr[k]),
            .wdata  (stg_wdata[k*CW +: CW]),
            .upd    (upd),
            .lock   (lock_q),
            .act_q  (act_val[k*CW +: CW]),
            .pend_q (pend[k])
        );
    end

    cmp_lock_ctrl u_lock (
        .clk         (clk),
        .rst         (rst),
        .alock_wr    (alock_wr),
        .alock_wdata (alock_wdata),
        .lock_wr     (lock_wr),
        .lock_wdata  (lock_wdata),
        .upd         (upd),
        .all_ready   (all_ready),
        .lock_q      (lock_q),
        .auto_q      (auto_q)
    );

    assign lock = lock_q;

    // R1: first cycle after reset shows the cleared state
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (act_val == '0 && pend == '0 && !lock));

endmodule

// File: tb/sim_cmp_update_ctrl.sv
module sim_cmp_update_ctrl;

    localparam int NCH = 3;
    localparam int CW  = 16;

    logic              clk = 1'b0;
    logic              rst;
    logic [NCH-1:0]    stg_wr;
    logic [NCH*CW-1:0] stg_wdata;
    logic [NCH-1:0]    ch_en;
    logic              alock_wr, alock_wdata, lock_wr, lock_wdata, upd;
    logic [NCH*CW-1:0] act_val;
    logic [NCH-1:0]    pend;
    logic              lock;

    always #2.5 clk = ~clk;

    cmp_update_ctrl #(.NCH(NCH), .CW(CW)) u0 (
        .clk(clk), .rst(rst), .stg_wr(stg_wr), .stg_wdata(stg_wdata),
        .ch_en(ch_en), .alock_wr(alock_wr), .alock_wdata(alock_wdata),
        .lock_wr(lock_wr), .lock_wdata(lock_wdata), .upd(upd),
        .act_val(act_val), .pend(pend), .lock(lock)
    );

    int n_chk = 0;
    int n_bad = 0;

    // bench model
    logic [CW-1:0]  m_act [NCH];
    logic [CW-1:0]  m_stg [NCH];
    logic [NCH-1:0] m_pend;
    logic           m_lock, m_auto;

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic logic [NCH*CW-1:0] model_act();
        logic [NCH*CW-1:0] v;
        for (int k = 0; k < NCH; k++) v[k*CW +: CW] = m_act[k];
        return v;
    endfunction

    function automatic logic model_ready();
        logic ok = 1'b1;
        for (int k = 0; k < NCH; k++) if (ch_en[k] && !m_pend[k]) ok = 1'b0;
        return ok;
    endfunction

    task automatic model_reset();
        for (int k = 0; k < NCH; k++) begin m_act[k] = '0; m_stg[k] = '0; end
        m_pend = '0; m_lock = 1'b0; m_auto = 1'b0;
    endtask

    task automatic model_step();
        logic xfer, rdy, nl;
        xfer = upd && !m_lock;
        rdy  = model_ready();
        for (int k = 0; k < NCH; k++) begin
            if (xfer && m_pend[k]) begin m_act[k] = m_stg[k]; m_pend[k] = 1'b0; end
            if (stg_wr[k]) begin m_stg[k] = stg_wdata[k*CW +: CW]; m_pend[k] = 1'b1; end
        end
        nl = m_lock;
        if (alock_wr && alock_wdata)          nl = 1'b1;
        else if (lock_wr)                     nl = lock_wdata;
        else if (m_auto && m_lock && rdy)     nl = 1'b0;
        else if (m_auto && !m_lock && upd)    nl = 1'b1;
        m_lock = nl;
        if (alock_wr) m_auto = alock_wdata;
    endtask

    task automatic idle();
        stg_wr = '0; alock_wr = 0; alock_wdata = 0;
        lock_wr = 0; lock_wdata = 0; upd = 0;
    endtask

    // one clock: model follows the driven inputs, outputs compared at the next low phase
    task automatic cycle(input string t_act, input string t_pend, input string t_lock);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check(t_act,  64'(act_val), 64'(model_act()));
        check(t_pend, 64'(pend),    64'(m_pend));
        check(t_lock, 64'(lock),    64'(m_lock));
        idle();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        idle(); stg_wdata = '0; ch_en = '1; rst = 1;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 act", 64'(act_val), 64'd0);
        check("R1 pend", 64'(pend), 64'd0);
        check("R1 lock", 64'(lock), 64'd0);

        // R8: manual lock only, no automatic lock
        lock_wr = 1; lock_wdata = 1; cycle("R8", "R8", "R8");
        stg_wr = 3'b111; stg_wdata = {16'h3333, 16'h2222, 16'h1111};
        cycle("R2", "R2", "R8");
        upd = 1; cycle("R4", "R4", "R8");              // locked: nothing moves
        check("R4 act held", 64'(act_val), 64'd0);
        lock_wr = 1; lock_wdata = 0; cycle("R8", "R8", "R8");
        upd = 1; cycle("R3", "R3", "R8");
        check("R3 act moved", 64'(act_val), 64'h3333_2222_1111);

        // R5 force lock by automatic-lock enable
        alock_wr = 1; alock_wdata = 1; cycle("R5", "R5", "R5");
        check("R5 lock set", 64'(lock), 64'd1);
        // R6 write channels one by one; lock holds until the last
        stg_wr = 3'b001; stg_wdata = {CW*NCH{1'b0}} | 48'h0000_0000_00a1; cycle("R2", "R2", "R6");
        stg_wr = 3'b010; stg_wdata = 48'h0000_00b2_0000; cycle("R2", "R2", "R6");
        check("R6 still locked", 64'(lock), 64'd1);
        stg_wr = 3'b100; stg_wdata = 48'h00c3_0000_0000; cycle("R2", "R2", "R6");
        cycle("R6", "R6", "R6");
        check("R6 released", 64'(lock), 64'd0);
        // R7 transfer with concurrent write (R9), then re-arm
        upd = 1; stg_wr = 3'b010; stg_wdata = 48'h0000_0dd4_0000;
        cycle("R9", "R9", "R7");
        check("R7 rearmed", 64'(lock), 64'd1);
        check("R9 old moved", 64'(act_val), 64'h00c3_00b2_00a1);
        check("R9 new pending", 64'(pend), 64'b010);
        // R6 disabled channels ignored
        ch_en = 3'b010; cycle("R6", "R6", "R6");
        check("R6 disabled ignored", 64'(lock), 64'd0);
        // R10 manual write overrides re-arm
        upd = 1; lock_wr = 1; lock_wdata = 0; cycle("R10", "R10", "R10");
        check("R10 manual wins", 64'(lock), 64'd0);
        alock_wr = 1; alock_wdata = 1; lock_wr = 1; lock_wdata = 0;
        cycle("R10", "R10", "R10");
        check("R10 force wins", 64'(lock), 64'd1);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            for (int k = 0; k < NCH; k++) stg_wr[k] = ($urandom % 4) == 0;
            stg_wdata = {16'($urandom), 16'($urandom), 16'($urandom)};
            upd = (r[3:0] < 5);
            alock_wr = (r[9:4] == 0); alock_wdata = r[10] | r[11];
            lock_wr = (r[16:12] == 0); lock_wdata = r[17];
            if (r[24:18] == 0) ch_en = 3'($urandom);
            cycle("R3", "R2", "R6");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule